// File: doc/BRIEF.md
# Interrupt Entry and Privilege Controller

This block runs alongside a simple multi-cycle processor core and owns the machine's status state: the pending request lines, the interrupt-enable flag, the privileged-mode flag, a countdown timer and the saved program counter. It holds the core idle until the supply reports that power is good. It then starts execution at a fixed boot address in privileged mode with interrupts masked, and walks each instruction through its five execution steps.

At every instruction boundary the controller decides whether to issue the next instruction or to divert into a handler. When it diverts, it masks interrupts, raises privilege, saves the current program counter and loads the handler address from a small vector table. Requests come from external lines, from the system-call and privileged-opcode decode flags the core raises during its decode step, from rejected status writes, and from the countdown timer. A register-style write port lets privileged code fill the vector table, load the timer and update the status flags.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `pwr_ok_i` is low no instruction is issued, and after reset `step_o` reads 0 (waiting), `priv_mode_o` is 1, `ints_en_o` is 0 and `pc_o` is the boot address (default 0x0000_0100).
- R2: In the cycle after the waiting state sees `pwr_ok_i` high, `pc_o` equals the boot address, `ints_en_o` is 0 and `priv_mode_o` is 1. A low `pwr_ok_i` at a boundary returns the block to the waiting state.
- R3: A request arriving while an instruction is in flight is latched into `req_pend_o` and does not alter the step sequence of that instruction.
- R4: An issued instruction walks `step_o` through 2 (fetch), 3 (decode), 4 (execute), 5 (memory) and 6 (write-back), one clock each, then returns to 1 (boundary). At write-back `pc_o` takes `wb_next_pc_i`.
- R5: At a boundary (`step_o` = 1, power good) with a pending request and interrupts enabled, `irq_taken_o` pulses instead of `issue_o`. On the next cycle `saved_pc_o` holds the old `pc_o`, `pc_o` holds the vector entry of the accepted number, `ints_en_o` is 0 and `priv_mode_o` is 1.
- R6: At a boundary with requests pending but interrupts disabled, `issue_o` pulses and the requests stay pending.
- R7: Among pending requests the lowest number is accepted, and only that bit is cleared. A request raised on the same line in the entry cycle stays pending.
- R8: Write address k < 8 stores `csr_wdata_i` into vector entry k. Address 8 is status (bit 0 interrupt enable, bit 1 privileged). Address 9 loads the timer. Any of these writes made outside privileged mode is discarded.
- R9: Software never sets privileged mode: a privileged status write may clear bit 1 but not set it, and a user-mode write is discarded and raises request 0.
- R10: `dec_priv_op_i` during the decode step raises request 0 when privileged mode is off, and has no effect in privileged mode.
- R11: `dec_svc_i` during the decode step raises request 1 in either mode.
- R12: A loaded timer counts down once every `TICK_DIV` cycles, stops at zero and raises request 2 exactly once per load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok_i | input | 1 | Supply reports stable power |
| ext_req_i | input | NUM_VEC | External request pulses, one per interrupt number |
| dec_priv_op_i | input | 1 | Core decoded a privileged opcode |
| dec_svc_i | input | 1 | Core decoded a system-call opcode |
| wb_next_pc_i | input | XLEN | Next program counter produced by the core at write-back |
| csr_we_i | input | 1 | Status-port write strobe |
| csr_addr_i | input | CSR_AW | Status-port write address |
| csr_wdata_i | input | XLEN | Status-port write data |
| issue_o | output | 1 | Instruction issued this cycle |
| irq_taken_o | output | 1 | Interrupt entry performed this cycle |
| pc_o | output | XLEN | Current program counter |
| saved_pc_o | output | XLEN | Program counter saved at the last entry |
| step_o | output | 3 | Sequencer step code |
| ints_en_o | output | 1 | Interrupt-enable flag |
| priv_mode_o | output | 1 | Privileged-mode flag |
| req_pend_o | output | NUM_VEC | Pending request bits |
| timer_val_o | output | TIMER_W | Countdown timer value |

## Verification
Two collisions get the most attention. One is interrupt entry landing on the same cycle as a fresh request on the line being accepted; the bench pulses that line in the very cycle `irq_taken_o` is high and expects the bit still pending afterwards. The other is an enable write arriving on the same edge as an entry. The random phase writes the enable bit on random cycles, some of which fall on an entry, and after every entry it expects `ints_en_o` to be 0 and `pc_o` to hold the vector of the lowest pending number seen at the boundary.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_WAIT  = 3'd0,
      ST_BOUND = 3'd1,
      ST_FETCH = 3'd2,
      ST_DEC   = 3'd3,
      ST_EXEC  = 3'd4,
      ST_MEM   = 3'd5,
      ST_WB    = 3'd6
   } step_e;

   localparam int STATUS_IE_BIT   = 0;
   localparam int STATUS_PRIV_BIT = 1;

endpackage

// File: rtl/irq_pend_arb.sv
module irq_pend_arb #(
   parameter int N  = 8,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  set_i,
   input  logic          take_i,
   output logic [N-1:0]  pend_o,
   output logic          any_o,
   output logic [IW-1:0] win_o
);
   logic [N-1:0] pend_q;
   logic [N-1:0] clr;
   logic         found;

   // lowest number wins
   always_comb begin
      win_o = '0;
      found = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (pend_q[i] && !found) begin
            win_o = IW'(i);
            found = 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_clr
      assign clr[g] = take_i && (win_o == IW'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | set_i;
   end

   assign pend_o = pend_q;
   assign any_o  = |pend_q;
endmodule

// File: rtl/irq_cdt_timer.sv
module irq_cdt_timer #(
   parameter int W   = 16,
   parameter int DIV = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] val_o,
   output logic         fire_o
);
   logic         tick;
   logic [W-1:0] cnt_q;
   logic         armed_q;

   if (DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    pre_q <= '0;
         else if (pre_q == PW'(DIV-1))  pre_q <= '0;
         else                           pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(DIV-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= load_val_i;
         armed_q <= 1'b1;
      end else begin
         if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         if (armed_q && cnt_q == '0) armed_q <= 1'b0;
      end
   end

   assign fire_o = armed_q && (cnt_q == '0);
   assign val_o  = cnt_q;
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
   parameter int N    = 8,
   parameter int XLEN = 32,
   localparam int IW  = $clog2(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  logic [IW-1:0]   widx_i,
   input  logic [XLEN-1:0] wdata_i,
   input  logic [IW-1:0]   ridx_i,
   output logic [XLEN-1:0] rdata_o
);
   logic [XLEN-1:0] ent_q [N];

   for (genvar g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             ent_q[g] <= '0;
         else if (we_i && widx_i == IW'(g))      ent_q[g] <= wdata_i;
      end
   end

   assign rdata_o = ent_q[ridx_i];
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              NUM_VEC   = 8,
   parameter int              CSR_AW    = 4,
   parameter int              TIMER_W   = 16,
   parameter int              TICK_DIV  = 4,
   parameter int              NUM_ERR   = 0,
   parameter int              NUM_SVC   = 1,
   parameter int              NUM_TMR   = 2,
   parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0000_0100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pwr_ok_i,
   input  logic [NUM_VEC-1:0] ext_req_i,
   input  logic               dec_priv_op_i,
   input  logic               dec_svc_i,
   input  logic [XLEN-1:0]    wb_next_pc_i,
   input  logic               csr_we_i,
   input  logic [CSR_AW-1:0]  csr_addr_i,
   input  logic [XLEN-1:0]    csr_wdata_i,
   output logic               issue_o,
   output logic               irq_taken_o,
   output logic [XLEN-1:0]    pc_o,
   output logic [XLEN-1:0]    saved_pc_o,
   output logic [2:0]         step_o,
   output logic               ints_en_o,
   output logic               priv_mode_o,
   output logic [NUM_VEC-1:0] req_pend_o,
   output logic [TIMER_W-1:0] timer_val_o
);
   localparam int IW = $clog2(NUM_VEC);
   localparam logic [CSR_AW-1:0] ADDR_STAT = CSR_AW'(NUM_VEC);
   localparam logic [CSR_AW-1:0] ADDR_TMR  = CSR_AW'(NUM_VEC + 1);

   if (NUM_VEC < 4 || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_nvec
      $error("NUM_VEC must be a power of two of at least 4");
   end
   if ((1 << CSR_AW) < NUM_VEC + 2) begin : g_bad_aw
      $error("CSR_AW too narrow for table, status and timer");
   end
   if (TIMER_W > XLEN || NUM_ERR >= NUM_VEC || NUM_SVC >= NUM_VEC || NUM_TMR >= NUM_VEC) begin : g_bad_num
      $error("timer width or internal request numbers out of range");
   end

   step_e           st_q;
   logic [XLEN-1:0] pc_q, saved_q;
   logic            ie_q, priv_q;

   logic               any_req, take, boundary, boot;
   logic [IW-1:0]      win;
   logic [NUM_VEC-1:0] set_req, internal_req;
   logic               hit_vec, hit_stat, hit_tmr, wr_ok, wr_reject;
   logic               tmr_fire;
   logic [XLEN-1:0]    vec_rd;

   // write port decode
   assign hit_vec   = csr_we_i && (csr_addr_i < ADDR_STAT);
   assign hit_stat  = csr_we_i && (csr_addr_i == ADDR_STAT);
   assign hit_tmr   = csr_we_i && (csr_addr_i == ADDR_TMR);
   assign wr_ok     = priv_q;
   assign wr_reject = (hit_vec || hit_stat || hit_tmr) && !priv_q;

   // internal request sources
   for (genvar g = 0; g < NUM_VEC; g++) begin : g_src
      if (g == NUM_ERR) begin : g_err
         assign internal_req[g] = wr_reject || (st_q == ST_DEC && dec_priv_op_i && !priv_q);
      end else if (g == NUM_SVC) begin : g_svc
         assign internal_req[g] = (st_q == ST_DEC) && dec_svc_i;
      end else if (g == NUM_TMR) begin : g_tmr
         assign internal_req[g] = tmr_fire;
      end else begin : g_none
         assign internal_req[g] = 1'b0;
      end
   end
   assign set_req = internal_req | ext_req_i;

   irq_pend_arb #(.N(NUM_VEC)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_req),
      .take_i (take),
      .pend_o (req_pend_o),
      .any_o  (any_req),
      .win_o  (win)
   );

   irq_cdt_timer #(.W(TIMER_W), .DIV(TICK_DIV)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (hit_tmr && wr_ok),
      .load_val_i (csr_wdata_i[TIMER_W-1:0]),
      .val_o      (timer_val_o),
      .fire_o     (tmr_fire)
   );

   irq_vec_table #(.N(NUM_VEC), .XLEN(XLEN)) u_vec (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (hit_vec && wr_ok),
      .widx_i  (csr_addr_i[IW-1:0]),
      .wdata_i (csr_wdata_i),
      .ridx_i  (win),
      .rdata_o (vec_rd)
   );

   // boundary decision
   assign boot     = (st_q == ST_WAIT) && pwr_ok_i;
   assign boundary = (st_q == ST_BOUND) && pwr_ok_i;
   assign take     = boundary && any_req && ie_q;
   assign issue_o  = boundary && !(any_req && ie_q);
   assign irq_taken_o = take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_WAIT;
      end else begin
         unique case (st_q)
            ST_WAIT:  if (pwr_ok_i) st_q <= ST_BOUND;
            ST_BOUND: if (!pwr_ok_i) st_q <= ST_WAIT;
                      else if (issue_o) st_q <= ST_FETCH;
            ST_FETCH: st_q <= ST_DEC;
            ST_DEC:   st_q <= ST_EXEC;
            ST_EXEC:  st_q <= ST_MEM;
            ST_MEM:   st_q <= ST_WB;
            ST_WB:    st_q <= ST_BOUND;
            default:  st_q <= ST_WAIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= BOOT_ADDR;
         saved_q <= '0;
         ie_q    <= 1'b0;
         priv_q  <= 1'b1;
      end else begin
         if (boot) begin
            pc_q   <= BOOT_ADDR;
            ie_q   <= 1'b0;
            priv_q <= 1'b1;
         end else if (take) begin
            saved_q <= pc_q;
            pc_q    <= vec_rd;
            ie_q    <= 1'b0;
            priv_q  <= 1'b1;
         end else begin
            if (st_q == ST_WB) pc_q <= wb_next_pc_i;
            if (hit_stat && wr_ok) begin
               ie_q   <= csr_wdata_i[STATUS_IE_BIT];
               priv_q <= priv_q & csr_wdata_i[STATUS_PRIV_BIT];
            end
         end
      end
   end

   assign pc_o        = pc_q;
   assign saved_pc_o  = saved_q;
   assign step_o      = st_q;
   assign ints_en_o   = ie_q;
   assign priv_mode_o = priv_q;
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk #(
   parameter int              XLEN      = 32,
   parameter int              NUM_VEC   = 8,
   parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0000_0100
) (
   input logic               clk,
   input logic               rst_n,
   input logic               pwr_ok,
   input logic               issue,
   input logic               irq_taken,
   input logic [XLEN-1:0]    pc,
   input logic [XLEN-1:0]    saved_pc,
   input logic [2:0]         step,
   input logic               ints_en,
   input logic               priv_mode,
   input logic [NUM_VEC-1:0] req_pend
);
   AST_ISSUE_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> pwr_ok); // R1

   AST_BOOT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd0 && pwr_ok) |=> (pc == BOOT_ADDR && priv_mode && !ints_en)); // R2

   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (step >= 3'd2 && step <= 3'd5) |=> (step == $past(step) + 3'd1)); // R4

   AST_WB_TO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd6) |=> (step == 3'd1)); // R4

   AST_ENTRY_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |=> (saved_pc == $past(pc) && !ints_en && priv_mode)); // R5

   AST_DISABLED_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
      (step == 3'd1 && pwr_ok && !ints_en) |-> issue); // R6

   AST_TAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_taken |-> (req_pend != '0 && !issue)); // R7

   AST_PRIV_HW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(priv_mode) |-> ($past(irq_taken) || $past(step) == 3'd0)); // R9
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk #(
   .XLEN(XLEN), .NUM_VEC(NUM_VEC), .BOOT_ADDR(BOOT_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_ok    (pwr_ok_i),
   .issue     (issue_o),
   .irq_taken (irq_taken_o),
   .pc        (pc_o),
   .saved_pc  (saved_pc_o),
   .step      (step_o),
   .ints_en   (ints_en_o),
   .priv_mode (priv_mode_o),
   .req_pend  (req_pend_o)
);

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
   localparam int XLEN = 32;
   localparam int NV   = 8;
   localparam logic [31:0] BOOT = 32'h0000_0100;
   localparam logic [3:0] A_STAT = 4'd8;
   localparam logic [3:0] A_TMR  = 4'd9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_ok = 1'b0;
   logic [NV-1:0] ext_req = '0;
   logic dec_priv = 1'b0, dec_svc = 1'b0;
   logic [XLEN-1:0] wb_next_pc;
   logic csr_we = 1'b0;
   logic [3:0] csr_addr = '0;
   logic [XLEN-1:0] csr_wdata = '0;
   logic issue, taken, ie, priv;
   logic [XLEN-1:0] pc, saved;
   logic [2:0] step;
   logic [NV-1:0] pend;
   logic [15:0] tval;

   int checks = 0;
   int fails  = 0;
   logic [31:0] vec_model [NV];

   always #10 clk = ~clk;   // 50 MHz

   assign wb_next_pc = pc + 32'd4;

   irq_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .ext_req_i(ext_req),
      .dec_priv_op_i(dec_priv), .dec_svc_i(dec_svc), .wb_next_pc_i(wb_next_pc),
      .csr_we_i(csr_we), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata),
      .issue_o(issue), .irq_taken_o(taken), .pc_o(pc), .saved_pc_o(saved),
      .step_o(step), .ints_en_o(ie), .priv_mode_o(priv), .req_pend_o(pend),
      .timer_val_o(tval)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int lowest(input logic [NV-1:0] m);
      for (int i = 0; i < NV; i++) if (m[i]) return i;
      return 0;
   endfunction

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic wait_step(input logic [2:0] s);
      for (int n = 0; n < 100 && step != s; n++) nxt();
   endtask

   task automatic csr_wr(input logic [3:0] a, input logic [31:0] d);
      csr_we = 1'b1; csr_addr = a; csr_wdata = d;
      nxt();
      csr_we = 1'b0;
   endtask

   // enable interrupts during the next instruction, then return at the boundary
   task automatic enable_and_wait();
      wait_step(3'd3);
      csr_wr(A_STAT, 32'd3);
      wait_step(3'd1);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] old_pc;
      logic [31:0] exp_pc;
      bit pend_chk;
      int dummy;
      bit seen;
      dummy = $urandom(32'h0000_5eed);
      for (int i = 0; i < NV; i++) vec_model[i] = 32'h0000_1000 + 32'(i) * 32'h100;

      repeat (3) nxt();
      rst_n = 1'b1;
      nxt();
      // R1 reset state
      chk("R1 step", step, 0); chk("R1 priv", priv, 1);
      chk("R1 ie", ie, 0); chk("R1 pc", pc, BOOT);
      seen = 0;
      for (int i = 0; i < 10; i++) begin nxt(); if (issue) seen = 1; end
      chk("R1 no issue without power", seen, 0);

      // R2 boot
      pwr_ok = 1'b1;
      nxt();
      chk("R2 boundary", step, 1); chk("R2 pc", pc, BOOT);
      chk("R2 priv", priv, 1); chk("R2 ie", ie, 0); chk("R2 issue", issue, 1);

      // R4 step walk
      for (int s = 2; s <= 6; s++) begin nxt(); chk("R4 step", step, s); end
      nxt();
      chk("R4 back to boundary", step, 1); chk("R4 pc advance", pc, BOOT + 4);

      // R8 fill vector table
      for (int i = 0; i < NV; i++) csr_wr(4'(i), vec_model[i]);

      // R3 / R6 request while disabled
      wait_step(3'd3);
      ext_req[5] = 1'b1; nxt(); ext_req = '0;
      chk("R3 latched", pend[5], 1); chk("R3 step continues", step, 4);
      wait_step(3'd1);
      chk("R6 issue while disabled", issue, 1); chk("R6 no entry", taken, 0);

      // R5 entry
      enable_and_wait();
      chk("R5 taken", taken, 1);
      old_pc = pc;
      nxt();
      chk("R5 pc vector", pc, vec_model[5]); chk("R5 saved", saved, old_pc);
      chk("R5 ie cleared", ie, 0); chk("R5 priv", priv, 1); chk("R5 req cleared", pend[5], 0);

      // R7 priority and same-cycle re-raise
      wait_step(3'd3);
      ext_req = 8'b0101_0000; nxt(); ext_req = '0;
      enable_and_wait();
      chk("R7 taken", taken, 1);
      ext_req[4] = 1'b1; nxt(); ext_req = '0;
      chk("R7 lowest wins", pc, vec_model[4]);
      chk("R7 re-raised stays", pend[4], 1); chk("R7 other stays", pend[6], 1);
      enable_and_wait(); nxt();
      chk("R7 second entry", pc, vec_model[4]);
      enable_and_wait(); nxt();
      chk("R7 third entry", pc, vec_model[6]); chk("R7 drained", pend, 0);

      // R12 timer
      csr_wr(A_TMR, 32'd3);
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin nxt(); if (pend[2]) seen = 1; end
      chk("R12 timer fired", seen, 1); chk("R12 timer zero", tval, 0);
      enable_and_wait(); nxt();
      chk("R12 entry vector", pc, vec_model[2]); chk("R12 cleared", pend[2], 0);
      repeat (60) nxt();
      chk("R12 fires once", pend[2], 0);

      // random phase: R5 R7
      pend_chk = 0; exp_pc = '0;
      for (int c = 0; c < 800; c++) begin
         if (pend_chk) begin
            chk("R5 random pc", pc, exp_pc); chk("R5 random ie", ie, 0);
            pend_chk = 0;
         end
         if (step == 3'd1 && pwr_ok) begin
            if (ie && pend != '0) begin
               chk("R7 random taken", taken, 1);
               exp_pc = vec_model[lowest(pend)];
               pend_chk = 1;
            end else chk("R6 random issue", issue, 1);
         end
         ext_req = '0;
         if ($urandom_range(0, 5) == 0) ext_req[$urandom_range(3, 7)] = 1'b1;
         csr_we = ($urandom_range(0, 7) == 0);
         csr_addr = A_STAT; csr_wdata = 32'd3;
         nxt();
      end
      ext_req = '0; csr_we = 1'b0;
      nxt();
      if (pend_chk) begin chk("R5 random pc", pc, exp_pc); pend_chk = 0; end
      for (int k = 0; k < 20 && pend != '0; k++) begin enable_and_wait(); nxt(); end
      wait_step(3'd3);
      if (ie) csr_wr(A_STAT, 32'd2);
      chk("R7 drain", pend, 0);

      // R10 privileged opcode in privileged mode
      wait_step(3'd3);
      dec_priv = 1'b1; nxt(); dec_priv = 1'b0;
      chk("R10 no trap in priv", pend[0], 0);

      // R11 system call
      wait_step(3'd3);
      dec_svc = 1'b1; nxt(); dec_svc = 1'b0;
      chk("R11 svc raised", pend[1], 1);
      enable_and_wait(); nxt();
      chk("R11 svc vector", pc, vec_model[1]);

      // R10 privileged opcode in user mode
      wait_step(3'd3);
      csr_wr(A_STAT, 32'd1);
      chk("R9 priv cleared", priv, 0); chk("R9 ie set", ie, 1);
      wait_step(3'd3);
      dec_priv = 1'b1; nxt(); dec_priv = 1'b0;
      chk("R10 trap raised", pend[0], 1);
      wait_step(3'd1);
      chk("R10 taken", taken, 1);
      nxt();
      chk("R10 error vector", pc, vec_model[0]); chk("R10 priv back", priv, 1);

      // R9 / R8 user writes rejected
      wait_step(3'd3);
      csr_wr(A_STAT, 32'd0);
      chk("R9 user mode", priv, 0);
      csr_wr(A_STAT, 32'd3);
      chk("R9 priv not set", priv, 0); chk("R8 ie not set", ie, 0);
      chk("R9 reject trap", pend[0], 1);
      csr_wr(A_TMR, 32'd5);
      chk("R8 timer write rejected", tval, 0);

      // R2 power loss
      wait_step(3'd1);
      pwr_ok = 1'b0;
      #1 chk("R1 no issue at low power", issue, 0);
      nxt();
      chk("R2 back to wait", step, 0);
      pwr_ok = 1'b1;
      nxt();
      chk("R2 reboot pc", pc, BOOT); chk("R2 reboot priv", priv, 1);
      chk("R2 reboot ie", ie, 0);

      finish_run();
   end
endmodule